// File: doc/BRIEF.md
# Posted-CAS DDR2 Command Latency Scheduler

This block sits on the controller side of a double-data-rate memory interface. Each clock it can take one command: a bank activate, a read or a write, with a bank number and an auto-precharge flag. It keeps an open or closed state for each of eight banks and rejects commands that do not fit that state. Accepted column commands are posted early. They are held in a short pipe for the programmed additive latency, then launched toward the data path.

After launch the block raises a read-capture window or a write-drive window at the exact clock the data must move. The window stays high for as many clocks as the burst occupies. Data moves on both edges, so that is half the burst length. When a column command asks for auto-precharge, the block closes that bank by itself once the burst ends and raises a one-clock precharge request for that bank.

Each bank has a three-state machine:
- BK_IDLE is the closed state. Activate moves it to BK_ACTIVE.
- In BK_ACTIVE, a column command with auto-precharge moves it to BK_AUTOPRE and loads the closing counter.
- In BK_AUTOPRE the counter runs down. When it expires the bank returns to BK_IDLE.
- Every other command leaves the state where it is.

Top module: `ddr2_lat_sched`

## Requirements
- R1: A command with cmd_op 2'b00 (activate) to a closed bank b opens it, and bank_open[b] reads 1 from the clock after the command. Other banks keep their state, so several banks can be open at once.
- R2: Read latency RL is cfg_al plus cfg_cl. cfg_al values above 6 count as 6. cfg_cl is clamped into the range 3 to 6. For a read (cmd_op 2'b01) accepted at clock edge k, rd_win is high after edges k+RL through k+RL+N-1 and low otherwise.
- R3: Write latency is RL minus one. For a write (cmd_op 2'b10) accepted at edge k, wr_win is high after edges k+RL-1 through k+RL+N-2, and rd_win stays low.
- R4: The window length N is 4 clocks when cfg_bl8 is 1 (burst of 8) and 2 clocks when cfg_bl8 is 0 (burst of 4).
- R5: Two reads accepted exactly N clocks apart give one contiguous rd_win of 2N clocks with no gap.
- R6: A read or write to a bank that is not in BK_ACTIVE is rejected, and so is an activate to a bank that is not in BK_IDLE. A rejected command leaves bank_open unchanged and produces no window.
- R7: err_flag is 0 after reset and becomes 1 from the clock after any rejected command. It stays 1 until reset.
- R8: A column command with cmd_ap=1 to bank b closes that bank after edge k+L+N, where L is RL for a read and RL-1 for a write. In the same clock, pre_req[b] is high for exactly one clock and bank_open[b] becomes 0. Until that clock any command to b is rejected. Afterwards a column command to b is rejected until a new activate is accepted.
- R9: When self-timed precharges of two banks end in the same clock, both bits of pre_req are high in that clock.
- R10: cmd_op 2'b11 is ignored. It changes no bank state, opens no window and does not set err_flag.
- R11: After reset all banks are closed and rd_win, wr_win, pre_req and err_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 activate, 01 read, 10 write, 11 ignored |
| cmd_bank | input | 3 | Target bank |
| cmd_ap | input | 1 | Auto-precharge request on a column command |
| cfg_al | input | 3 | Additive latency, 0 to 6 |
| cfg_cl | input | 3 | CAS latency, 3 to 6 |
| cfg_bl8 | input | 1 | 1 for burst of 8, 0 for burst of 4 |
| rd_win | output | 1 | Read-capture data window enable |
| wr_win | output | 1 | Write-drive data window enable |
| pre_req | output | 8 | One-clock self-timed precharge request, one bit per bank |
| bank_open | output | 8 | Open-row state, one bit per bank |
| err_flag | output | 1 | Sticky illegal-command flag |

## Verification
Self-timed precharges of two banks can end in the same clock, because a write runs one clock shorter than a read. The bench provokes this with an auto-precharge read to bank 0, followed one clock later by an auto-precharge write to bank 1, both at AL 0, CL 3 and burst of 4. It then expects pre_req to read 2'b11 in exactly one clock, five clocks after the read, with both banks closed in that clock and pre_req zero in the clocks around it. A second case checks that an activate is still rejected when it meets a bank that is in the middle of its closing countdown.

// File: rtl/ddr2_sched_pkg.sv
package ddr2_sched_pkg;

    typedef enum logic [1:0] {
        OP_ACT  = 2'b00,
        OP_RD   = 2'b01,
        OP_WR   = 2'b10,
        OP_NONE = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_ACTIVE,
        BK_AUTOPRE
    } bank_st_e;

    typedef struct packed {
        logic vld;
        logic wr;
    } post_ent_t;

endpackage

// File: rtl/ddr2_bank_fsm.sv
module ddr2_bank_fsm
    import ddr2_sched_pkg::*;
#(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  cmd_op_e          op,
    input  logic             ap,
    input  logic [LAT_W-1:0] span,
    output logic             is_open,
    output logic             pre_pulse,
    output logic             reject
);

    bank_st_e         state, state_nxt;
    logic [LAT_W-1:0] cnt, cnt_nxt;
    logic             is_col;
    logic             pre_q;

    assign is_col = (op == OP_RD) || (op == OP_WR);
    assign reject = sel && (((op == OP_ACT) && (state != BK_IDLE)) ||
                            (is_col && (state != BK_ACTIVE)));

    // next-state logic
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            BK_IDLE: begin
                if (sel && (op == OP_ACT)) state_nxt = BK_ACTIVE;
            end
            BK_ACTIVE: begin
                if (sel && is_col && ap) begin
                    state_nxt = BK_AUTOPRE;
                    cnt_nxt   = span;
                end
            end
            BK_AUTOPRE: begin
                if (cnt == LAT_W'(1)) state_nxt = BK_IDLE;
                else                  cnt_nxt   = cnt - LAT_W'(1);
            end
            default: state_nxt = BK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= BK_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= 1'b0;
        else        pre_q <= (state == BK_AUTOPRE) && (cnt == LAT_W'(1));
    end

    assign pre_pulse = pre_q;
    assign is_open   = (state != BK_IDLE);

    AST_REJECT_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && (state != BK_AUTOPRE)) |=> (state == $past(state))); // R6

    AST_AP_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        pre_pulse |-> (state == BK_IDLE)); // R8

endmodule

// File: rtl/ddr2_post_queue.sv
module ddr2_post_queue
    import ddr2_sched_pkg::*;
#(
    parameter int MAX_AL = 6,
    parameter int AL_W   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic            in_wr,
    input  logic [AL_W-1:0] al,
    output logic            out_vld,
    output logic            out_wr
);

    generate
        if (MAX_AL == 0) begin : g_bypass
            assign out_vld = in_vld;
            assign out_wr  = in_wr;
        end else begin : g_pipe
            post_ent_t pipe [MAX_AL];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < MAX_AL; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= '{vld: in_vld, wr: in_wr};
                    for (int i = 1; i < MAX_AL; i++) pipe[i] <= pipe[i-1];
                end
            end

            always_comb begin
                out_vld = in_vld;
                out_wr  = in_wr;
                for (int i = 1; i <= MAX_AL; i++) begin
                    if (int'(al) == i) begin
                        out_vld = pipe[i-1].vld;
                        out_wr  = pipe[i-1].wr;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ddr2_win_gen.sv
module ddr2_win_gen #(
    parameter int DEPTH = 10,
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [LAT_W-1:0] lat,
    input  logic [LAT_W-1:0] n,
    output logic             win
);

    logic [DEPTH-1:0] occ, mask;

    always_comb begin
        mask = '0;
        for (int i = 0; i < DEPTH; i++) begin
            mask[i] = issue && (i >= int'(lat)) && (i < int'(lat) + int'(n));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= (occ >> 1) | mask;
    end

    assign win = occ[0];

    AST_WIN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> ((int'(lat) + int'(n)) <= DEPTH)); // R4

endmodule

// File: rtl/ddr2_lat_sched.sv
module ddr2_lat_sched
    import ddr2_sched_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_W    = $clog2(NUM_BANKS),
    parameter int AL_W      = 3,
    parameter int CL_W      = 3,
    parameter int MAX_AL    = 6,
    parameter int MIN_CL    = 3,
    parameter int MAX_CL    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic                 cmd_ap,
    input  logic [AL_W-1:0]      cfg_al,
    input  logic [CL_W-1:0]      cfg_cl,
    input  logic                 cfg_bl8,
    output logic                 rd_win,
    output logic                 wr_win,
    output logic [NUM_BANKS-1:0] pre_req,
    output logic [NUM_BANKS-1:0] bank_open,
    output logic                 err_flag
);

    localparam int BURST_MAX = 4;
    localparam int WIN_DEPTH = MAX_CL + BURST_MAX;
    localparam int LAT_W     = $clog2(MAX_AL + MAX_CL + BURST_MAX + 1);

    cmd_op_e              op;
    logic [AL_W-1:0]      al_eff;
    logic [CL_W-1:0]      cl_eff;
    logic [LAT_W-1:0]     rl, wl, nburst, span;
    logic [NUM_BANKS-1:0] rej_vec;
    logic                 any_rej, col_acc, iss_vld, iss_wr;
    logic                 err_q;

    assign op = cmd_op_e'(cmd_op);

    // configuration clamping and latency arithmetic
    always_comb begin
        al_eff = (int'(cfg_al) > MAX_AL) ? AL_W'(MAX_AL) : cfg_al;
        if (int'(cfg_cl) < MIN_CL)      cl_eff = CL_W'(MIN_CL);
        else if (int'(cfg_cl) > MAX_CL) cl_eff = CL_W'(MAX_CL);
        else                            cl_eff = cfg_cl;
        rl     = LAT_W'(al_eff) + LAT_W'(cl_eff);
        wl     = rl - LAT_W'(1);
        nburst = cfg_bl8 ? LAT_W'(4) : LAT_W'(2);
        span   = ((op == OP_WR) ? wl : rl) + nburst;
    end

    // per-bank state machines
    genvar b;
    generate
        for (b = 0; b < NUM_BANKS; b++) begin : g_bank
            ddr2_bank_fsm #(.LAT_W(LAT_W)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .sel       (cmd_valid && (int'(cmd_bank) == b)),
                .op        (op),
                .ap        (cmd_ap),
                .span      (span),
                .is_open   (bank_open[b]),
                .pre_pulse (pre_req[b]),
                .reject    (rej_vec[b])
            );
        end
    endgenerate

    assign any_rej = |rej_vec;
    assign col_acc = cmd_valid && ((op == OP_RD) || (op == OP_WR)) && !any_rej;

    // additive-latency posting
    ddr2_post_queue #(.MAX_AL(MAX_AL), .AL_W(AL_W)) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (col_acc),
        .in_wr   (op == OP_WR),
        .al      (al_eff),
        .out_vld (iss_vld),
        .out_wr  (iss_wr)
    );

    // data windows, measured from the launch after posting
    ddr2_win_gen #(.DEPTH(WIN_DEPTH), .LAT_W(LAT_W)) u_rd_win (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (iss_vld && !iss_wr),
        .lat   (LAT_W'(cl_eff)),
        .n     (nburst),
        .win   (rd_win)
    );

    ddr2_win_gen #(.DEPTH(WIN_DEPTH), .LAT_W(LAT_W)) u_wr_win (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (iss_vld && iss_wr),
        .lat   (LAT_W'(cl_eff) - LAT_W'(1)),
        .n     (nburst),
        .win   (wr_win)
    );

    // sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | any_rej;
    end

    assign err_flag = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R7

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 2'b00) && !bank_open[cmd_bank])
        |=> bank_open[$past(cmd_bank)]); // R1

endmodule

// File: tb/ddr2_lat_sched_tb.sv
module ddr2_lat_sched_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b11;
    logic [2:0] cmd_bank = '0;
    logic       cmd_ap = 1'b0;
    logic [2:0] cfg_al = '0;
    logic [2:0] cfg_cl = 3'd3;
    logic       cfg_bl8 = 1'b0;
    logic       rd_win, wr_win, err_flag;
    logic [7:0] pre_req, bank_open;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [1:0] C_ACT = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_NOP = 2'b11;

    always #2 clk = ~clk;

    ddr2_lat_sched u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
        .cfg_bl8(cfg_bl8), .rd_win(rd_win), .wr_win(wr_win), .pre_req(pre_req),
        .bank_open(bank_open), .err_flag(err_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at a falling edge, accepted at the next rising edge, return one falling edge later
    task automatic send(input logic [1:0] op, input int bank, input bit ap);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = 3'(bank); cmd_ap = ap;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = C_NOP; cmd_ap = 1'b0;
    endtask

    task automatic col_check(input string req, input logic [1:0] op, input int bank,
                             input bit ap, input int al, input int cl, input bit bl8);
        int rl, lat, n;
        bit is_wr;
        cfg_al = 3'(al); cfg_cl = 3'(cl); cfg_bl8 = bl8;
        rl    = (al > 6 ? 6 : al) + (cl < 3 ? 3 : (cl > 6 ? 6 : cl));
        is_wr = (op == C_WR);
        lat   = is_wr ? rl - 1 : rl;
        n     = bl8 ? 4 : 2;
        send(op, bank, ap);
        for (int j = 1; j <= lat + n + 1; j++) begin
            @(negedge clk);
            chk(req, is_wr ? "wr_win" : "rd_win", is_wr ? int'(wr_win) : int'(rd_win),
                int'(j >= lat && j < lat + n));
            chk(req, is_wr ? "rd_win idle" : "wr_win idle",
                is_wr ? int'(rd_win) : int'(wr_win), 0);
            if (ap) begin
                chk("R8", "pre_req", int'(pre_req[bank]), int'(j == lat + n));
                chk("R8", "bank_open", int'(bank_open[bank]), int'(j < lat + n));
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R11", "rd_win", int'(rd_win), 0);
        chk("R11", "wr_win", int'(wr_win), 0);
        chk("R11", "pre_req", int'(pre_req), 0);
        chk("R11", "bank_open", int'(bank_open), 0);
        chk("R11", "err_flag", int'(err_flag), 0);
    endtask

    task automatic t_activate();
        send(C_ACT, 2, 0);
        chk("R1", "bank_open", int'(bank_open), 8'h04);
        send(C_ACT, 6, 0);
        chk("R1", "bank_open two banks", int'(bank_open), 8'h44);
        chk("R1", "err_flag", int'(err_flag), 0);
    endtask

    task automatic t_latencies();
        col_check("R2", C_RD, 2, 0, 0, 3, 0);
        col_check("R4", C_RD, 6, 0, 3, 5, 1);
        col_check("R2", C_RD, 2, 0, 6, 6, 1);
        col_check("R2", C_RD, 6, 0, 7, 2, 0);
        col_check("R3", C_WR, 2, 0, 2, 4, 1);
        col_check("R3", C_WR, 6, 0, 0, 3, 0);
        chk("R1", "banks still open", int'(bank_open), 8'h44);
    endtask

    task automatic t_gapless();
        cfg_al = 3'd1; cfg_cl = 3'd3; cfg_bl8 = 1'b0;
        send(C_RD, 2, 0);
        @(negedge clk);
        chk("R5", "rd_win j1", int'(rd_win), 0);
        send(C_RD, 6, 0);
        for (int j = 3; j <= 9; j++) begin
            @(negedge clk);
            chk("R5", "rd_win contiguous", int'(rd_win), int'(j >= 4 && j <= 7));
        end
    endtask

    task automatic t_reject();
        do_reset();
        send(C_RD, 5, 0);
        chk("R6", "bank_open after read to closed", int'(bank_open), 0);
        chk("R7", "err_flag set", int'(err_flag), 1);
        repeat (8) begin
            @(negedge clk);
            chk("R6", "no window", int'(rd_win | wr_win), 0);
        end
        send(C_ACT, 2, 0);
        chk("R7", "err_flag sticky", int'(err_flag), 1);
        send(C_ACT, 2, 0);
        chk("R6", "bank_open after double act", int'(bank_open), 8'h04);
        col_check("R6", C_RD, 2, 0, 0, 3, 0);
        chk("R7", "err_flag still", int'(err_flag), 1);
    endtask

    task automatic t_autopre();
        do_reset();
        send(C_ACT, 3, 0);
        col_check("R8", C_RD, 3, 1, 0, 3, 0);
        send(C_RD, 3, 0);
        chk("R8", "err_flag after read to closed", int'(err_flag), 1);
        repeat (6) begin
            @(negedge clk);
            chk("R8", "no window after close", int'(rd_win), 0);
        end
        do_reset();
        send(C_ACT, 4, 0);
        col_check("R8", C_WR, 4, 1, 1, 4, 1);
        chk("R8", "err_flag clean", int'(err_flag), 0);
    endtask

    task automatic t_pending_reject();
        do_reset();
        cfg_al = 3'd0; cfg_cl = 3'd3; cfg_bl8 = 1'b0;
        send(C_ACT, 1, 0);
        send(C_RD, 1, 1);
        send(C_ACT, 1, 0);
        chk("R8", "act during countdown rejected", int'(err_flag), 1);
        for (int j = 2; j <= 6; j++) begin
            @(negedge clk);
            chk("R8", "pre_req bank1", int'(pre_req[1]), int'(j == 5));
            chk("R8", "bank_open bank1", int'(bank_open[1]), int'(j < 5));
        end
    endtask

    task automatic t_dual_pre();
        do_reset();
        cfg_al = 3'd0; cfg_cl = 3'd3; cfg_bl8 = 1'b0;
        send(C_ACT, 0, 0);
        send(C_ACT, 1, 0);
        send(C_RD, 0, 1);
        send(C_WR, 1, 1);
        for (int j = 2; j <= 7; j++) begin
            @(negedge clk);
            chk("R9", "pre_req", int'(pre_req), (j == 5) ? 3 : 0);
            chk("R9", "bank_open", int'(bank_open), (j >= 5) ? 0 : 3);
        end
        chk("R9", "err_flag", int'(err_flag), 0);
    endtask

    task automatic t_ignored();
        do_reset();
        send(C_NOP, 4, 1);
        for (int j = 1; j <= 12; j++) begin
            @(negedge clk);
            chk("R10", "windows", int'(rd_win | wr_win), 0);
        end
        chk("R10", "bank_open", int'(bank_open), 0);
        chk("R10", "err_flag", int'(err_flag), 0);
        send(C_ACT, 4, 0);
        send(C_NOP, 4, 0);
        chk("R10", "bank_open kept", int'(bank_open), 8'h10);
        chk("R10", "err_flag kept", int'(err_flag), 0);
    endtask

    initial begin
        t_reset();
        t_activate();
        t_latencies();
        t_gapless();
        t_reject();
        t_autopre();
        t_pending_reject();
        t_dual_pre();
        t_ignored();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule